// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns single-word writes to a dispatch register into control actions on a set of processor cores. Each write names a target core, one of four commands and a 6-bit vector. The block keeps a run bit for every core, produces one-cycle reset pulses, and forwards interrupt posts to the processor interrupt port.

The four commands are: post an interrupt, reset the core and start it, halt the core, and resume the core. A halted core does not restart when an interrupt is posted to it. Only a resume or a reset command sets it running again. A reset command is carried out only when its vector equals the power-on-reset code. Any other vector drops the command and raises an error pulse. A command that names a core at or above the configured count is dropped with no effect.

All outputs are registered. The effect of a write taken at a clock edge is visible on the outputs after that same edge.

Top module: `ipi_dispatch`

## Requirements
- R1: Fields are taken from the write word as follows: command in bits 17:16, core ID in bits 12:8, vector in bits 5:0. All other bits are ignored. A write takes effect only when `wr_en` is high.
- R2: Command 0 (post) drives `post_valid` high for one cycle, with `post_cpu` and `post_vec` taken from the write. It does not change any run bit.
- R3: Command 1 (reset) with vector equal to `POR_VEC` (default 6'h01) gives a one-cycle pulse on `cpu_rst_pulse` for the target core. The same cycle shows that core's run bit set. At most one reset pulse bit is high at a time.
- R4: Command 1 with any other vector raises `cmd_err` for one cycle. It gives no reset pulse and changes no run bit.
- R5: Command 2 (halt) clears the target core's run bit.
- R6: A halted core stays halted when an interrupt is posted to it. The post itself is still forwarded.
- R7: Command 3 (resume) sets the target core's run bit without a reset pulse.
- R8: A command whose core ID is greater than or equal to `NUM_CPU` is dropped. It produces no post, no pulse, no error and no run-bit change.
- R9: After system reset only core 0's run bit is set. `cpu_rst_pulse`, `post_valid` and `cmd_err` are low.
- R10: `post_valid`, `cmd_err` and the reset pulses are single-cycle. Each returns low in the cycle after the command unless a new command drives it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the dispatch register |
| wr_data | input | 32 | Write data (command, core ID, vector) |
| cpu_run | output | NUM_CPU | Run state per core, 1 = running |
| cpu_rst_pulse | output | NUM_CPU | One-cycle reset pulse per core |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | Target core of the post |
| post_vec | output | 6 | Vector of the post |
| cmd_err | output | 1 | One-cycle pulse for a reset command with a wrong vector |

## Verification
Two actions can fall in the same cycle: a core's reset pulse and the setting of its run bit. A valid reset command is sent to a core that is stopped. The bench samples once after the edge and requires both the one-hot pulse and the new run bit in that sample. One cycle later it requires the pulse to be gone while the run bit stays set. A second overlap comes from posting to a halted core. The bench judges it by seeing the post strobe together with an unchanged cleared run bit.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CPU_ID_W = 5;
    localparam int VEC_W    = 6;

    // Field positions in the dispatch write word
    localparam int KIND_LSB = 16;
    localparam int ID_LSB   = 8;
    localparam int VEC_LSB  = 0;

    typedef enum logic [1:0] {
        KIND_POST   = 2'd0,
        KIND_RESET  = 2'd1,
        KIND_HALT   = 2'd2,
        KIND_RESUME = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e             kind;
        logic [CPU_ID_W-1:0]   cpu;
        logic [VEC_W-1:0]      vec;
    } cmd_word_t;

    function automatic cmd_word_t unpack_cmd(input logic [31:0] w);
        cmd_word_t c;
        c.kind = cmd_kind_e'(w[KIND_LSB +: 2]);
        c.cpu  = w[ID_LSB +: CPU_ID_W];
        c.vec  = w[VEC_LSB +: VEC_W];
        return c;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int             NUM_CPU = 4,
    parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output cmd_word_t          cmd,
    output logic [NUM_CPU-1:0] sel,
    output logic               do_post,
    output logic               do_reset,
    output logic               do_halt,
    output logic               do_resume,
    output logic               bad_reset
);
    logic in_range;
    logic live;

    always_comb begin
        cmd      = unpack_cmd(wr_data);
        in_range = int'(cmd.cpu) < NUM_CPU;
        live     = wr_en && in_range;
    end

    generate
        for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
            assign sel[i] = live && (int'(cmd.cpu) == i);
        end
    endgenerate

    always_comb begin
        do_post   = 1'b0;
        do_reset  = 1'b0;
        do_halt   = 1'b0;
        do_resume = 1'b0;
        bad_reset = 1'b0;
        if (live) begin
            unique case (cmd.kind)
                KIND_POST:   do_post   = 1'b1;
                KIND_RESET:  begin
                    do_reset  = (cmd.vec == POR_VEC);
                    bad_reset = (cmd.vec != POR_VEC);
                end
                KIND_HALT:   do_halt   = 1'b1;
                KIND_RESUME: do_resume = 1'b1;
            endcase
        end
    end

    always_comb begin
        a_sel_onehot_r8: assert ($onehot0(sel));
    end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot #(
    parameter bit RUN_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic do_reset,
    input  logic do_halt,
    input  logic do_resume,
    output logic run,
    output logic rst_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= RUN_AT_RESET;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= hit && do_reset;
            if (hit && (do_reset || do_resume))
                run <= 1'b1;
            else if (hit && do_halt)
                run <= 1'b0;
        end
    end

    p_pulse_with_run_r3: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> run);

    p_halt_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && do_halt) |=> !run);

    p_resume_no_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && do_resume) |=> (run && !rst_pulse));
endmodule

// File: rtl/ipi_post.sv
module ipi_post
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_word_t           cmd,
    input  logic                do_post,
    input  logic                bad_reset,
    output logic                post_valid,
    output logic [CPU_ID_W-1:0] post_cpu,
    output logic [VEC_W-1:0]    post_vec,
    output logic                cmd_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
            cmd_err    <= 1'b0;
        end else begin
            post_valid <= do_post;
            cmd_err    <= bad_reset;
            if (do_post) begin
                post_cpu <= cmd.cpu;
                post_vec <= cmd.vec;
            end
        end
    end

    p_err_excl_post_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !post_valid);

    p_post_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> (int'(post_cpu) < NUM_CPU));
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int             NUM_CPU = 4,
    parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [NUM_CPU-1:0]  cpu_run,
    output logic [NUM_CPU-1:0]  cpu_rst_pulse,
    output logic                post_valid,
    output logic [CPU_ID_W-1:0] post_cpu,
    output logic [VEC_W-1:0]    post_vec,
    output logic                cmd_err
);
    cmd_word_t          cmd;
    logic [NUM_CPU-1:0] sel;
    logic do_post, do_reset, do_halt, do_resume, bad_reset;

    ipi_decode #(.NUM_CPU(NUM_CPU), .POR_VEC(POR_VEC)) u_decode (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cmd       (cmd),
        .sel       (sel),
        .do_post   (do_post),
        .do_reset  (do_reset),
        .do_halt   (do_halt),
        .do_resume (do_resume),
        .bad_reset (bad_reset)
    );

    generate
        for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
            ipi_cpu_slot #(.RUN_AT_RESET(i == 0)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .hit       (sel[i]),
                .do_reset  (do_reset),
                .do_halt   (do_halt),
                .do_resume (do_resume),
                .run       (cpu_run[i]),
                .rst_pulse (cpu_rst_pulse[i])
            );
        end
    endgenerate

    ipi_post #(.NUM_CPU(NUM_CPU)) u_post (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .do_post    (do_post),
        .bad_reset  (bad_reset),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec),
        .cmd_err    (cmd_err)
    );

    p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cpu_rst_pulse));

    p_bad_reset_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (cpu_rst_pulse == '0));

    p_no_write_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!post_valid && !cmd_err && cpu_rst_pulse == '0));
endmodule

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [31:0]  wr_data;
    logic [N-1:0] cpu_run;
    logic [N-1:0] cpu_rst_pulse;
    logic         post_valid;
    logic [4:0]   post_cpu;
    logic [5:0]   post_vec;
    logic         cmd_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ipi_dispatch #(.NUM_CPU(N), .POR_VEC(6'h01)) u_ipi_dispatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cpu_run(cpu_run), .cpu_rst_pulse(cpu_rst_pulse),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
        .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int kind, input int cpu, input int vec);
        return (32'(kind) << 16) | (32'(cpu & 31) << 8) | 32'(vec & 63);
    endfunction

    // Drive one write; returns at the next falling edge, after the taking edge.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R9 run", 32'(cpu_run), 32'h1);
        chk("R9 pulse", 32'(cpu_rst_pulse), 32'h0);
        chk("R9 post", 32'(post_valid), 32'h0);
        chk("R9 err", 32'(cmd_err), 32'h0);
    endtask

    task automatic t_post();
        issue(word(0, 2, 6'h2A));
        chk("R2 post_valid", 32'(post_valid), 32'h1);
        chk("R2 post_cpu", 32'(post_cpu), 32'h2);
        chk("R2 post_vec", 32'(post_vec), 32'h2A);
        chk("R2 run unchanged", 32'(cpu_run), 32'h1);
        idle_cycle();
        chk("R10 post drops", 32'(post_valid), 32'h0);
        issue(32'hFFFC_03FF & (word(0, 3, 6'h3F) | 32'hFFFC_00C0));
        chk("R1 extra bits post_valid", 32'(post_valid), 32'h1);
        chk("R1 extra bits cpu", 32'(post_cpu), 32'h3);
        chk("R1 extra bits vec", 32'(post_vec), 32'h3F);
    endtask

    task automatic t_reset_cmd();
        issue(word(1, 1, 6'h01));
        chk("R3 pulse", 32'(cpu_rst_pulse), 32'h2);
        chk("R3 run same cycle", 32'(cpu_run), 32'h3);
        idle_cycle();
        chk("R10 pulse drops", 32'(cpu_rst_pulse), 32'h0);
        chk("R3 run held", 32'(cpu_run), 32'h3);
    endtask

    task automatic t_bad_reset();
        issue(word(1, 2, 6'h05));
        chk("R4 err", 32'(cmd_err), 32'h1);
        chk("R4 no pulse", 32'(cpu_rst_pulse), 32'h0);
        chk("R4 run unchanged", 32'(cpu_run), 32'h3);
        idle_cycle();
        chk("R10 err drops", 32'(cmd_err), 32'h0);
    endtask

    task automatic t_halt_post_resume();
        issue(word(2, 1, 0));
        chk("R5 halt", 32'(cpu_run), 32'h1);
        issue(word(0, 1, 6'h11));
        chk("R6 post forwarded", 32'(post_valid), 32'h1);
        chk("R6 stays halted", 32'(cpu_run), 32'h1);
        idle_cycle();
        chk("R6 still halted", 32'(cpu_run), 32'h1);
        issue(word(3, 1, 0));
        chk("R7 resume", 32'(cpu_run), 32'h3);
        chk("R7 no pulse", 32'(cpu_rst_pulse), 32'h0);
        issue(word(2, 0, 0));
        chk("R5 halt core 0", 32'(cpu_run), 32'h2);
    endtask

    task automatic t_out_of_range();
        issue(word(3, N, 0));
        chk("R8 resume dropped", 32'(cpu_run), 32'h2);
        issue(word(1, 31, 6'h01));
        chk("R8 reset dropped pulse", 32'(cpu_rst_pulse), 32'h0);
        chk("R8 reset dropped run", 32'(cpu_run), 32'h2);
        issue(word(1, 7, 6'h09));
        chk("R8 no err", 32'(cmd_err), 32'h0);
        issue(word(0, 31, 6'h22));
        chk("R8 no post", 32'(post_valid), 32'h0);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = word(1, 2, 6'h01);
        @(negedge clk);
        chk("R1 no strobe pulse", 32'(cpu_rst_pulse), 32'h0);
        chk("R1 no strobe run", 32'(cpu_run), 32'h2);
        wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_post();
        t_reset_cmd();
        t_bad_reset();
        t_halt_post_resume();
        t_out_of_range();
        t_no_strobe();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule